// File: doc/BRIEF.md
# Line BIP-8 Generator and Inserter

This block sits in the transmit path of an STS-1 or STS-3 line interface. It runs on the byte stream before the scrambler. Every byte arrives with a class tag that marks it as section overhead, a line byte, or a B2 slot. It also carries the index of the interleaved STS-1 it belongs to, and a frame-start marker on the first byte of each frame. For each interleaved STS-1 the block keeps a running even-parity BIP-8 over the outgoing bytes of that channel, with section overhead left out. At each frame start the running value moves into a holding register. That held value is written into the channel's B2 slot during the frame that follows.

Two maintenance functions are built into the same path. Line AIS replaces every byte that is not section overhead with all ones. This includes the B2 slots. The parity is taken after this fill. Per-channel error insertion works from an enable vector and a one-shot strobe. A strobe marks the enabled channels as pending, and the next B2 slot of each marked channel goes out bit-inverted, once.

Top module: `line_bip_inserter`

## Requirements
- R1: Every output is registered. `valid_o` and `data_o` show, one clock later, the result for the byte that was presented with `valid_i` high.
- R2: With AIS off, a byte tagged line (class 0) or reserved (class 3) passes to the output unchanged.
- R3: A byte tagged section overhead (class 1) passes unchanged even while AIS is on, and it never enters the parity.
- R4: While `ais_en_i` is high, every valid byte that is not section overhead goes out as 8'hFF. This includes B2 slots.
- R5: A B2 slot (class 2) for channel k carries the even BIP-8 of the outgoing non-section-overhead bytes of channel k in the previous frame. A frame runs from one valid frame-start byte to the next. The covered bytes include inserted B2 values and AIS fill.
- R6: A strobe while `err_en_i[k]` is set makes the next B2 slot of channel k go out inverted. A strobe in the same cycle as that slot applies to that slot. The request is then cleared, even when AIS masks the slot, so later slots are clean.
- R7: A strobe while `err_en_i[k]` is clear has no effect on channel k.
- R8: After reset `valid_o` and `data_o` are zero. The accumulators start at zero, so the B2 slots of the first frame carry 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input byte present |
| data_i | input | 8 | Input byte |
| class_i | input | 2 | Byte class: 0 line, 1 section overhead, 2 B2 slot, 3 reserved (treated as line) |
| sts_sel_i | input | SEL_W | Interleaved STS-1 index of the byte |
| frame_start_i | input | 1 | First byte of a frame (used only with valid_i) |
| ais_en_i | input | 1 | Line AIS fill enable |
| err_en_i | input | NUM_STS | Per-channel B2 error enables |
| err_strobe_i | input | 1 | One-shot error insertion strobe |
| valid_o | output | 1 | Output byte present |
| data_o | output | 8 | Output byte |

## Verification
Each byte's result shows up on `data_o` one clock after it is presented. The bench therefore drives a byte on a falling edge and compares the output on the next falling edge against a value its model computed when the byte was driven. A B2 value depends on everything driven since the frame start before last. Its expectation comes from model accumulators that are swapped at the same byte where the RTL swaps its own. An error strobe has no visible effect until the next B2 slot of its channel, one clock after that slot is driven. The model holds the request as a pending flag until then. The sequence covers strobes before, on and after a slot, with the enable clear, and while AIS is on.

// File: rtl/lbip_pkg.sv
package lbip_pkg;
  typedef enum logic [1:0] {
    BC_LINE = 2'd0,
    BC_SOH  = 2'd1,
    BC_B2   = 2'd2,
    BC_RSVD = 2'd3
  } byte_class_e;
endpackage

// File: rtl/lbip_err_latch.sv
module lbip_err_latch #(
  parameter int NUM_STS = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  logic [NUM_STS-1:0] en_i,
  input  logic [NUM_STS-1:0] consume_i,
  output logic [NUM_STS-1:0] eff_o,
  output logic [NUM_STS-1:0] pend_o
);
  for (genvar g = 0; g < NUM_STS; g++) begin : g_ch
    logic pend_q;
    // a strobe on the slot cycle itself is applied at once
    assign eff_o[g]  = pend_q | (strobe_i & en_i[g]);
    assign pend_o[g] = pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           pend_q <= 1'b0;
      else if (consume_i[g]) pend_q <= 1'b0;
      else                   pend_q <= eff_o[g];
    end
  end
endmodule

// File: rtl/lbip_parity_bank.sv
module lbip_parity_bank #(
  parameter int NUM_STS = 3,
  parameter int BYTE_W  = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            frame_start_i,
  input  logic [NUM_STS-1:0]              upd_i,
  input  logic [BYTE_W-1:0]               byte_i,
  output logic [NUM_STS-1:0][BYTE_W-1:0]  prev_o
);
  for (genvar g = 0; g < NUM_STS; g++) begin : g_acc
    logic [BYTE_W-1:0] acc_q, prev_q, base;
    assign base      = frame_start_i ? '0 : acc_q;
    assign prev_o[g] = prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q  <= '0;
        prev_q <= '0;
      end else begin
        acc_q <= base ^ (upd_i[g] ? byte_i : '0);
        if (frame_start_i) prev_q <= acc_q;
      end
    end
  end
endmodule

// File: rtl/line_bip_inserter.sv
module line_bip_inserter
  import lbip_pkg::*;
#(
  parameter  int NUM_STS = 3,
  parameter  int BYTE_W  = 8,
  localparam int SEL_W   = (NUM_STS > 1) ? $clog2(NUM_STS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [BYTE_W-1:0]  data_i,
  input  logic [1:0]         class_i,
  input  logic [SEL_W-1:0]   sts_sel_i,
  input  logic               frame_start_i,
  input  logic               ais_en_i,
  input  logic [NUM_STS-1:0] err_en_i,
  input  logic               err_strobe_i,
  output logic               valid_o,
  output logic [BYTE_W-1:0]  data_o
);
  byte_class_e                     cls;
  logic                            is_soh, is_b2, fs;
  logic [NUM_STS-1:0]              hit, consume, upd, eff, pend;
  logic [NUM_STS-1:0][BYTE_W-1:0]  prev;
  logic [BYTE_W-1:0]               b2_byte, out_byte;

  assign cls    = byte_class_e'(class_i);
  assign is_soh = (cls == BC_SOH);
  assign is_b2  = (cls == BC_B2);
  assign fs     = valid_i & frame_start_i;

  always_comb begin
    for (int k = 0; k < NUM_STS; k++)
      hit[k] = valid_i && (sts_sel_i == SEL_W'(k));
  end

  assign consume = hit & {NUM_STS{is_b2}};
  assign upd     = hit & {NUM_STS{~is_soh}};

  always_comb begin
    b2_byte = '0;
    for (int k = 0; k < NUM_STS; k++)
      if (hit[k]) b2_byte = prev[k] ^ {BYTE_W{eff[k]}};
  end

  always_comb begin
    if (is_soh)        out_byte = data_i;
    else if (ais_en_i) out_byte = '1;
    else if (is_b2)    out_byte = b2_byte;
    else               out_byte = data_i;
  end

  lbip_err_latch #(.NUM_STS(NUM_STS)) u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (err_strobe_i),
    .en_i      (err_en_i),
    .consume_i (consume),
    .eff_o     (eff),
    .pend_o    (pend)
  );

  lbip_parity_bank #(.NUM_STS(NUM_STS), .BYTE_W(BYTE_W)) u_par (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (fs),
    .upd_i         (upd),
    .byte_i        (out_byte),
    .prev_o        (prev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= out_byte;
    end
  end
endmodule

// File: rtl/lbip_checker.sv
module lbip_checker #(
  parameter int NUM_STS = 3,
  parameter int BYTE_W  = 8,
  parameter int SEL_W   = 2
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            valid_i,
  input logic [BYTE_W-1:0]               data_i,
  input logic [1:0]                      class_i,
  input logic [SEL_W-1:0]                sts_sel_i,
  input logic                            ais_en_i,
  input logic [NUM_STS-1:0]              err_en_i,
  input logic                            err_strobe_i,
  input logic                            valid_o,
  input logic [BYTE_W-1:0]               data_o,
  input logic [NUM_STS-1:0][BYTE_W-1:0]  prev_w,
  input logic [NUM_STS-1:0]              pend_w
);
  logic sel_ok;
  assign sel_ok = int'(sts_sel_i) < NUM_STS;

  AST_VALID_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i)); // R1
  AST_LINE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ais_en_i && (class_i == 2'd0 || class_i == 2'd3) |=> data_o == $past(data_i)); // R2
  AST_SOH_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && class_i == 2'd1 |=> data_o == $past(data_i)); // R3
  AST_AIS_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ais_en_i && class_i != 2'd1 |=> data_o == '1); // R4
  AST_B2_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && class_i == 2'd2 && sel_ok && !ais_en_i && !err_strobe_i && !pend_w[sts_sel_i]
    |=> data_o == $past(prev_w[sts_sel_i])); // R5
  AST_ERR_INVERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && class_i == 2'd2 && sel_ok && !ais_en_i && pend_w[sts_sel_i]
    |=> data_o == ~$past(prev_w[sts_sel_i])); // R6
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && class_i == 2'd2 && sel_ok && !err_strobe_i |=> !pend_w[$past(sts_sel_i)]); // R6

  for (genvar g = 0; g < NUM_STS; g++) begin : g_quiet
    AST_NO_SPURIOUS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pend_w[g] && !(err_strobe_i && err_en_i[g]) |=> !pend_w[g]); // R7
  end
endmodule

bind line_bip_inserter lbip_checker #(
  .NUM_STS(NUM_STS), .BYTE_W(BYTE_W), .SEL_W(SEL_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .data_i       (data_i),
  .class_i      (class_i),
  .sts_sel_i    (sts_sel_i),
  .ais_en_i     (ais_en_i),
  .err_en_i     (err_en_i),
  .err_strobe_i (err_strobe_i),
  .valid_o      (valid_o),
  .data_o       (data_o),
  .prev_w       (prev),
  .pend_w       (pend)
);

// File: tb/line_bip_inserter_test.sv
`timescale 1ns/1ps
module line_bip_inserter_test;
  localparam int N = 3, IW = 2, ROWS = 9, COLS = 90 * N;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_ni, valid_i, frame_start_i, ais_en_i, err_strobe_i;
  logic [7:0]     data_i;
  logic [1:0]     class_i;
  logic [IW-1:0]  sts_sel_i;
  logic [N-1:0]   err_en_i;
  logic           valid_o;
  logic [7:0]     data_o;

  line_bip_inserter #(.NUM_STS(N), .BYTE_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .class_i(class_i), .sts_sel_i(sts_sel_i), .frame_start_i(frame_start_i),
    .ais_en_i(ais_en_i), .err_en_i(err_en_i), .err_strobe_i(err_strobe_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] m_acc [N];
  logic [7:0] m_prev[N];
  bit         m_pend[N];
  bit         have_exp = 0, exp_v;
  logic [7:0] exp_d;
  string      exp_tag;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [7:0] d, logic [1:0] cls, int sel, bit fs,
                      bit ais, logic [N-1:0] en, bit stb, int fr);
    bit eff[N];
    logic [7:0] out;
    string tag;
    @(negedge clk);
    if (have_exp) begin
      chk(valid_o == exp_v, "R1", "valid_o", valid_o, exp_v);
      if (exp_v) chk(data_o == exp_d, exp_tag, "data_o", data_o, exp_d);
    end
    valid_i = v; data_i = d; class_i = cls; sts_sel_i = IW'(sel);
    frame_start_i = fs; ais_en_i = ais; err_en_i = en; err_strobe_i = stb;
    for (int k = 0; k < N; k++) eff[k] = m_pend[k] | (stb & en[k]);
    if (v && fs)
      for (int k = 0; k < N; k++) begin m_prev[k] = m_acc[k]; m_acc[k] = 8'h00; end
    if (cls == 2'd1)       begin out = d;    tag = "R3"; end
    else if (ais)          begin out = 8'hFF; tag = "R4"; end
    else if (cls == 2'd2) begin
      out = eff[sel] ? ~m_prev[sel] : m_prev[sel];
      if (fr == 0)          tag = "R8";
      else if (eff[sel])    tag = "R6";
      else if (fr == 1)     tag = "R7";
      else                  tag = "R5";
    end else               begin out = d;    tag = "R2"; end
    if (v && cls != 2'd1) m_acc[sel] ^= out;
    for (int k = 0; k < N; k++)
      m_pend[k] = (v && cls == 2'd2 && sel == k) ? 1'b0 : eff[k];
    exp_v = v; have_exp = 1;
    if (v) begin exp_d = out; exp_tag = tag; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int k = 0; k < N; k++) begin m_acc[k] = 0; m_prev[k] = 0; m_pend[k] = 0; end
    rst_ni = 0; valid_i = 0; data_i = 0; class_i = 0; sts_sel_i = 0;
    frame_start_i = 0; ais_en_i = 0; err_en_i = 0; err_strobe_i = 0;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R8", "reset valid_o", valid_o, 0);
    chk(data_o == 8'h00, "R8", "reset data_o", data_o, 0);
    rst_ni = 1;
    @(negedge clk);
    chk(valid_o == 1'b0 && data_o == 8'h00, "R8", "idle after reset", data_o, 0);
    for (int fr = 0; fr < 5; fr++) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          logic [1:0] cls;
          logic [N-1:0] en;
          bit stb;
          logic [7:0] d;
          cls = (r < 3 && c < 3 * N) ? 2'd1 : (r == 4 && c < N) ? 2'd2 :
                ((r + c) % 17 == 0) ? 2'd3 : 2'd0;
          d = 8'(fr * 53 + r * 29 + c * 11 + ((c * c) >> 3));
          stb = 0; en = '0;
          if (fr == 0 && r == 6 && c == 10) begin stb = 1; en = 3'b000; end
          if (fr == 1 && r == 2 && c == 20) begin stb = 1; en = 3'b101; end
          if (fr == 2 && r == 1 && c == 5)  begin stb = 1; en = 3'b010; end
          if (fr == 3 && r == 4 && c == 1)  begin stb = 1; en = 3'b010; end
          step(1, d, cls, c % N, (r == 0 && c == 0), fr == 2, en, stb, fr);
        end
      step(0, 8'h00, 2'd0, 0, 0, 0, '0, 0, fr);
      step(0, 8'h00, 2'd0, 0, 0, 0, '0, 0, fr);
    end
    step(0, 8'h00, 2'd0, 0, 0, 0, '0, 0, 5);
    finish_run();
  end
endmodule